// File: doc/BRIEF.md
# Triple-Redundant Output Voter with Replica Diagnosis

This block sits behind three identical copies of a logic unit that are fed the same inputs. It merges their three W-bit output words into one word by taking the majority of each bit. Any fault confined to one copy therefore never reaches the merged output.

Each copy is also compared against the merged word. A per-copy mismatch vector shows in the same cycle which copy has diverged. A registered flag per copy holds that fact until reset or an explicit clear. A separate flag shows when more than one copy diverges at once, which is the point where masking can no longer be trusted.

A parameter selects whether the merged word leaves the block directly or through a register. An injection input inverts one chosen bit of one chosen copy before the vote, so masking and diagnosis can be exercised on demand.

Top module: `tmr_vote_diag`

## Requirements
- R1: While rst_ni is low, sticky_o is 0 and, when OUT_REG=1, vote_o is 0.
- R2: Each bit of the voted word equals the value held by at least two of the three effective copies (copy inputs after injection).
- R3: When two effective copies are equal, the voted word equals them, whatever the third copy holds.
- R4: mis_o[k] is 1 in the same cycle exactly when effective copy k (k = 0, 1, 2 for rep0_i, rep1_i, rep2_i) differs in any bit from the combinational voted word.
- R5: sticky_o[k] becomes 1 at the clock edge after a cycle with mis_o[k]=1, and it stays 1 while clr_i is low.
- R6: multi_o is 1 in exactly those cycles where two or more bits of mis_o are 1.
- R7: A clock edge with clr_i=1 loads sticky_o with that cycle's mis_o, so a clear drops old flags but does not lose a disagreement seen in the same cycle.
- R8: With OUT_REG=0, vote_o follows the copies in the same cycle. With OUT_REG=1, vote_o shows the voted word of the previous cycle.
- R9: With inj_en_i=1 and inj_rep_i equal to 0, 1 or 2, bit inj_bit_i of that copy is inverted before voting and comparison. inj_rep_i=3 leaves all copies unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rep0_i | input | WIDTH | Output word of copy 0 |
| rep1_i | input | WIDTH | Output word of copy 1 |
| rep2_i | input | WIDTH | Output word of copy 2 |
| clr_i | input | 1 | Clears the sticky flags at the next edge |
| inj_en_i | input | 1 | Enables bit inversion on one copy |
| inj_rep_i | input | 2 | Copy selected for injection (3 = none) |
| inj_bit_i | input | $clog2(WIDTH) | Bit position inverted |
| vote_o | output | WIDTH | Majority word, direct or registered |
| mis_o | output | 3 | Per-copy disagreement with the voted word |
| sticky_o | output | 3 | Registered per-copy disagreement history |
| multi_o | output | 1 | Two or more copies disagree this cycle |

## Verification
The clear input and the setting of a sticky flag by a fresh disagreement can fall on the same clock edge. The bench provokes this with directed vectors that raise clr_i while one copy is corrupted. Random vectors also carry clr_i alongside random faults. After that edge, sticky_o is judged against a bench model that keeps only the bits disagreeing in that cycle. Injection on a copy that is already corrupted in the same cycle is also mixed in, and it is judged against the same effective-copy model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NREP = 3;
  typedef logic [NREP-1:0] rep_vec_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/tmr_inject.sv
module tmr_inject #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned BW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [tmr_pkg::NREP-1:0][WIDTH-1:0] rep_i,
  input  logic                                inj_en_i,
  input  logic [1:0]                          inj_rep_i,
  input  logic [BW-1:0]                       inj_bit_i,
  output logic [tmr_pkg::NREP-1:0][WIDTH-1:0] rep_o
);
  logic [WIDTH-1:0] bit_mask;
  assign bit_mask = WIDTH'(1) << inj_bit_i;

  for (genvar k = 0; k < tmr_pkg::NREP; k++) begin : g_rep
    logic hit;
    assign hit      = inj_en_i && (inj_rep_i == 2'(k));
    assign rep_o[k] = hit ? (rep_i[k] ^ bit_mask) : rep_i[k];
  end
endmodule

// File: rtl/tmr_majority.sv
module tmr_majority #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [tmr_pkg::NREP-1:0][WIDTH-1:0] rep_i,
  output logic [WIDTH-1:0]                    vote_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign vote_o[b] = tmr_pkg::maj3(rep_i[0][b], rep_i[1][b], rep_i[2][b]);
  end
endmodule

// File: rtl/tmr_diag.sv
module tmr_diag #(
  parameter int unsigned WIDTH = 8
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [tmr_pkg::NREP-1:0][WIDTH-1:0] rep_i,
  input  logic [WIDTH-1:0]                    vote_i,
  input  logic                                clr_i,
  output tmr_pkg::rep_vec_t                   mis_o,
  output tmr_pkg::rep_vec_t                   sticky_o,
  output logic                                multi_o
);
  tmr_pkg::rep_vec_t sticky_q;

  for (genvar k = 0; k < tmr_pkg::NREP; k++) begin : g_cmp
    assign mis_o[k] = |(rep_i[k] ^ vote_i);
  end

  assign multi_o = (mis_o[0] & mis_o[1]) | (mis_o[0] & mis_o[2]) | (mis_o[1] & mis_o[2]);

  // set has priority over clear so a same-cycle disagreement is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sticky_q <= '0;
    else if (clr_i) sticky_q <= mis_o;
    else            sticky_q <= sticky_q | mis_o;
  end

  assign sticky_o = sticky_q;
endmodule

// File: rtl/tmr_vote_diag.sv
module tmr_vote_diag #(
  parameter int unsigned WIDTH   = 8,
  parameter bit          OUT_REG = 1'b0,
  localparam int unsigned BW     = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] rep0_i,
  input  logic [WIDTH-1:0] rep1_i,
  input  logic [WIDTH-1:0] rep2_i,
  input  logic             clr_i,
  input  logic             inj_en_i,
  input  logic [1:0]       inj_rep_i,
  input  logic [BW-1:0]    inj_bit_i,
  output logic [WIDTH-1:0] vote_o,
  output logic [2:0]       mis_o,
  output logic [2:0]       sticky_o,
  output logic             multi_o
);
  logic [tmr_pkg::NREP-1:0][WIDTH-1:0] raw, eff;
  logic [WIDTH-1:0]                    vote_c;

  assign raw[0] = rep0_i;
  assign raw[1] = rep1_i;
  assign raw[2] = rep2_i;

  tmr_inject #(.WIDTH(WIDTH)) u_inject (
    .rep_i    (raw),
    .inj_en_i (inj_en_i),
    .inj_rep_i(inj_rep_i),
    .inj_bit_i(inj_bit_i),
    .rep_o    (eff)
  );

  tmr_majority #(.WIDTH(WIDTH)) u_major (
    .rep_i (eff),
    .vote_o(vote_c)
  );

  tmr_diag #(.WIDTH(WIDTH)) u_diag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rep_i   (eff),
    .vote_i  (vote_c),
    .clr_i   (clr_i),
    .mis_o   (mis_o),
    .sticky_o(sticky_o),
    .multi_o (multi_o)
  );

  if (OUT_REG) begin : g_oreg
    logic [WIDTH-1:0] vote_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vote_q <= '0;
      else         vote_q <= vote_c;
    end
    assign vote_o = vote_q;
  end else begin : g_ocomb
    assign vote_o = vote_c;
  end
endmodule

// File: rtl/tmr_vote_diag_chk.sv
module tmr_vote_diag_chk #(
  parameter int unsigned WIDTH   = 8,
  parameter bit          OUT_REG = 1'b0,
  localparam int unsigned BW     = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] rep0_i,
  input logic [WIDTH-1:0] rep1_i,
  input logic [WIDTH-1:0] rep2_i,
  input logic             clr_i,
  input logic             inj_en_i,
  input logic [1:0]       inj_rep_i,
  input logic [BW-1:0]    inj_bit_i,
  input logic [WIDTH-1:0] vote_o,
  input logic [2:0]       mis_o,
  input logic [2:0]       sticky_o,
  input logic             multi_o
);
  logic clean, pair01;
  assign clean  = !inj_en_i || (inj_rep_i == 2'd3);
  assign pair01 = clean && (rep0_i == rep1_i);

  a_r1_reset_sticky: assert property (@(posedge clk_i) !rst_ni |-> sticky_o == 3'b000);

  a_r4_no_mis_when_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clean && rep0_i == rep1_i && rep1_i == rep2_i) |-> mis_o == 3'b000);

  a_r6_multi_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_o == ($countones(mis_o) > 1));

  a_r5_sticky_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|mis_o) |=> ((sticky_o & $past(mis_o)) == $past(mis_o)));

  a_r5_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && |sticky_o) |=> ((sticky_o & $past(sticky_o)) == $past(sticky_o)));

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && mis_o == 3'b000) |=> sticky_o == 3'b000);

  a_r9_inj_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_en_i && inj_rep_i == 2'd3 && rep0_i == rep1_i && rep1_i == rep2_i) |-> mis_o == 3'b000);

  if (OUT_REG) begin : g_reg
    a_r8_vote_delayed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pair01 |=> vote_o == $past(rep0_i));
  end else begin : g_comb
    a_r3_vote_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pair01 |-> vote_o == rep0_i);
  end
endmodule

bind tmr_vote_diag tmr_vote_diag_chk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/tmr_vote_diag_tb.sv
`timescale 1ns/1ps
module tmr_vote_diag_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] r0 = '0, r1 = '0, r2 = '0;
  logic clr = 1'b0, inj_en = 1'b0;
  logic [1:0] inj_rep = 2'd0;
  logic [2:0] inj_bit = 3'd0;
  logic [W-1:0] vote_c, vote_r;
  logic [2:0] mis_c, mis_r, st_c, st_r;
  logic multi_c, multi_r;

  int n_vec = 0, n_err = 0;
  logic [2:0] exp_st = 3'b000;

  always #2.5 clk = ~clk;

  tmr_vote_diag #(.WIDTH(W), .OUT_REG(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rep0_i(r0), .rep1_i(r1), .rep2_i(r2),
    .clr_i(clr), .inj_en_i(inj_en), .inj_rep_i(inj_rep), .inj_bit_i(inj_bit),
    .vote_o(vote_c), .mis_o(mis_c), .sticky_o(st_c), .multi_o(multi_c));

  tmr_vote_diag #(.WIDTH(W), .OUT_REG(1'b1)) u_dut_reg (
    .clk_i(clk), .rst_ni(rst_n), .rep0_i(r0), .rep1_i(r1), .rep2_i(r2),
    .clr_i(clr), .inj_en_i(inj_en), .inj_rep_i(inj_rep), .inj_bit_i(inj_bit),
    .vote_o(vote_r), .mis_o(mis_r), .sticky_o(st_r), .multi_o(multi_r));

  function automatic logic [W-1:0] eff(input int k, input logic [W-1:0] v);
    if (inj_en && inj_rep == 2'(k)) return v ^ (W'(1) << inj_bit);
    return v;
  endfunction

  function automatic logic [W-1:0] maj(input logic [W-1:0] a, b, c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic vec(input logic [W-1:0] a, b, c, input logic en, input logic [1:0] rp,
                     input logic [2:0] bt, input logic cl);
    logic [W-1:0] e0, e1, e2, v;
    logic [2:0] m;
    logic mu;
    @(negedge clk);
    r0 = a; r1 = b; r2 = c; inj_en = en; inj_rep = rp; inj_bit = bt; clr = cl;
    #1;
    e0 = eff(0, a); e1 = eff(1, b); e2 = eff(2, c);
    v  = maj(e0, e1, e2);
    m  = {e2 != v, e1 != v, e0 != v};
    mu = $countones(m) > 1;
    chk(vote_c == v, "R2/R3/R9 vote", 32'(vote_c), 32'(v));
    chk(mis_c == m, "R4/R9 mismatch", 32'(mis_c), 32'(m));
    chk(multi_c == mu, "R6 multi", 32'(multi_c), 32'(mu));
    exp_st = cl ? m : (exp_st | m);
    @(posedge clk); #1;
    chk(st_c == exp_st, "R5/R7 sticky", 32'(st_c), 32'(exp_st));
    chk(vote_r == v, "R8 registered vote", 32'(vote_r), 32'(v));
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd1357));
    #12;
    // R1: reset state
    chk(st_c == 3'b000, "R1 sticky in reset", 32'(st_c), 0);
    chk(vote_r == '0, "R1 registered vote in reset", 32'(vote_r), 0);
    @(negedge clk); rst_n = 1'b1;

    vec(8'h5A, 8'h5A, 8'h5A, 0, 0, 0, 0);          // R2 clean
    vec(8'h5A, 8'h5A, 8'hA5, 0, 0, 0, 0);          // R3 copy 2 inverted
    vec(8'h3C, 8'hC3, 8'h3C, 0, 0, 0, 0);          // R3 copy 1 inverted
    vec(8'hFF, 8'h00, 8'h00, 0, 0, 0, 0);          // R3 copy 0 inverted
    vec(8'h11, 8'h11, 8'h11, 0, 0, 0, 0);          // R5 hold with no new mis
    vec(8'h11, 8'h11, 8'h11, 0, 0, 0, 1);          // R7 clear alone
    vec(8'h0F, 8'h0F, 8'h0E, 0, 0, 0, 1);          // R7 clear with same-cycle mis
    vec(8'h00, 8'h00, 8'h00, 1, 2'd0, 3'd7, 0);    // R9 inject copy 0 bit 7
    vec(8'h00, 8'h00, 8'h00, 1, 2'd1, 3'd0, 1);    // R9 inject copy 1 bit 0
    vec(8'h00, 8'h00, 8'h00, 1, 2'd2, 3'd3, 1);    // R9 inject copy 2 bit 3
    vec(8'h77, 8'h77, 8'h77, 1, 2'd3, 3'd2, 1);    // R9 select 3 has no effect
    vec(8'h01, 8'h02, 8'h04, 0, 0, 0, 1);          // R6 three-way divergence
    vec(8'hF0, 8'hF1, 8'hF0, 1, 2'd2, 3'd4, 1);    // R6 inject adds second fault

    for (int i = 0; i < 600; i++) begin : rnd
      logic [W-1:0] base, a, b, c;
      int mode;
      base = W'($urandom);
      a = base; b = base; c = base;
      mode = $urandom_range(0, 3);
      if (mode >= 1) case ($urandom_range(0, 2))
        0: a ^= W'($urandom);
        1: b ^= W'($urandom);
        default: c ^= W'($urandom);
      endcase
      if (mode == 3) b ^= W'(1) << $urandom_range(0, W - 1);
      vec(a, b, c, ($urandom_range(0, 3) == 0), 2'($urandom), 3'($urandom),
          ($urandom_range(0, 7) == 0));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule